// File: doc/BRIEF.md
# Elapsed-Time Counter with Compare Alarm

This block keeps a free-running binary count that advances once for each pulse of a 32768 Hz tick enable. The count is 48 bits wide, so bits 14:0 hold the fraction of a second and bits 47:15 hold whole seconds. Software sees the count as three 16-bit words on a small synchronous register port. A seconds value `s` is loaded by writing `s<<15` to the low word, `s>>1` to the middle word and `s>>17` to the high word. A seconds value is read back as `high<<17 | middle<<1 | low>>15`.

A 48-bit compare value uses the same three-word layout. When a tick moves the count onto the compare value, a sticky alarm flag is set. The flag is cleared when software writes a one to it. The interrupt output is the flag gated by an enable bit. The three count words are not captured together, so software reads all three twice and keeps the value only when both passes agree.

Reads are combinational from the address. Writes take effect at the clock edge on which `bus_wr` is high.

Top module: `elapsed_alarm_timer`

## Requirements
- R1: After reset, all count words, all compare words, the enable register and the status register read 0, and `irq` is low.
- R2: In each cycle where `tick_en` is high and no count word is written, the 48-bit count increases by one. Carries run from the low word into the middle word and from the middle word into the high word.
- R3: In a cycle where `tick_en` is low and no count word is written, the count does not change.
- R4: A write to offset 0x00, 0x02 or 0x04 replaces count bits 15:0, 31:16 or 47:32 respectively. The other words keep their values. A tick in the same cycle is dropped, and counting continues from the written value on the next tick. Bits 47:15 of the count are whole seconds.
- R5: The compare words at offsets 0x08, 0x0A and 0x0C (bits 15:0, 31:16 and 47:32) can be written and read back. They change only when written.
- R6: Status bit 0 at offset 0x1E is set on the tick that advances the count to equal the compare value. Writing a count or compare word so that the two become equal does not set it.
- R7: Writing a word with bit 0 set to offset 0x1E clears the flag. Writing a word with bit 0 clear leaves the flag as it is.
- R8: When a flag clear and a flag set fall in the same cycle, the flag ends up set.
- R9: `irq` equals the flag ANDed with bit 0 of the enable register at offset 0x10. The flag is set whether or not the enable bit is set.
- R10: Reads from unmapped offsets return 0, and writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle pulse at the 32768 Hz count rate |
| bus_addr | input | 5 | Byte offset of the register word |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| irq | output | 1 | Alarm interrupt (flag AND enable) |

## Verification
The assertions check the rules that hold on every cycle:
- the count moves by exactly one on an accepted tick and holds otherwise;
- the compare words stay put unless they are written;
- the flag rises only after an accepted tick;
- a clear takes effect when no set is pending, and a set wins over a clear in the same cycle.

Only the bench scenarios can show the address mapping and the carry across word boundaries. They also show the seconds layout, that a write drops the tick in its own cycle, and that writing a register until it matches raises no alarm.

// File: rtl/etime_pkg.sv
package etime_pkg;
   // Byte offset of word k in a bank of 16-bit words starting at base.
   function automatic int unsigned word_ofs(input int unsigned base, input int unsigned k);
      return base + 2 * k;
   endfunction
endpackage

// File: rtl/etime_counter.sv
module etime_counter #(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned NWORDS = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       tick_en,
   input  logic [NWORDS-1:0]          wsel,
   input  logic [WORD_W-1:0]          wdata,
   output logic [WORD_W*NWORDS-1:0]   cnt,
   output logic [WORD_W*NWORDS-1:0]   cnt_nxt,
   output logic                       adv
);
   localparam int unsigned CW = WORD_W * NWORDS;

   logic [CW-1:0] cnt_d;

   assign adv     = tick_en & ~(|wsel);
   assign cnt_nxt = cnt + CW'(1);

   always_comb begin
      cnt_d = adv ? cnt_nxt : cnt;
      for (int k = 0; k < int'(NWORDS); k++) begin
         if (wsel[k]) cnt_d[k*WORD_W +: WORD_W] = wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt_d;
   end

   // R2: an accepted tick adds exactly one
   a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && wsel == '0) |=> cnt == CW'($past(cnt) + CW'(1)));
   // R3: no tick and no write keeps the count
   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && wsel == '0) |=> $stable(cnt));
endmodule

// File: rtl/etime_alarm.sv
module etime_alarm #(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned NWORDS = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       adv,
   input  logic [WORD_W*NWORDS-1:0]   cnt_nxt,
   input  logic [NWORDS-1:0]          cmp_wsel,
   input  logic                       en_wr,
   input  logic                       stat_wr,
   input  logic [WORD_W-1:0]          wdata,
   output logic [WORD_W*NWORDS-1:0]   cmp,
   output logic                       en,
   output logic                       flag
);
   localparam int unsigned CW = WORD_W * NWORDS;

   logic hit_set;
   logic hit_clr;

   assign hit_set = adv && (cnt_nxt == cmp);
   assign hit_clr = stat_wr && wdata[0];

   for (genvar k = 0; k < NWORDS; k++) begin : g_cmp
      always_ff @(posedge clk) begin
         if (!rst_n)           cmp[k*WORD_W +: WORD_W] <= '0;
         else if (cmp_wsel[k]) cmp[k*WORD_W +: WORD_W] <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en   <= 1'b0;
         flag <= 1'b0;
      end else begin
         if (en_wr) en <= wdata[0];
         if (hit_set)      flag <= 1'b1;
         else if (hit_clr) flag <= 1'b0;
      end
   end

   // R5: compare holds unless written
   a_r5_cmp_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_wsel == '0) |=> $stable(cmp));
   // R6: the flag only rises after an accepted tick
   a_r6_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(adv));
   // R7: a clear with no set pending drops the flag
   a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_clr && !hit_set) |=> !flag);
   // R8: set wins over a simultaneous clear
   a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_set && hit_clr) |=> flag);
endmodule

// File: rtl/elapsed_alarm_timer.sv
module elapsed_alarm_timer #(
   parameter int unsigned WORD_W   = 16,
   parameter int unsigned NWORDS   = 3,
   parameter int unsigned ADDR_W   = 5,
   parameter int unsigned CNT_BASE = 'h00,
   parameter int unsigned CMP_BASE = 'h08,
   parameter int unsigned EN_OFS   = 'h10,
   parameter int unsigned STAT_OFS = 'h1E
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [WORD_W-1:0] bus_wdata,
   output logic [WORD_W-1:0] bus_rdata,
   output logic              irq
);
   import etime_pkg::*;

   localparam int unsigned CW = WORD_W * NWORDS;

   if (STAT_OFS >= (1 << ADDR_W) || EN_OFS >= (1 << ADDR_W)) begin : g_chk_addr
      $error("address width too small for register offsets");
   end
   if (CMP_BASE < CNT_BASE + 2 * NWORDS) begin : g_chk_overlap
      $error("compare bank overlaps count bank");
   end
   if (WORD_W < 2) begin : g_chk_word
      $error("word width must be at least 2");
   end

   logic [NWORDS-1:0] cnt_wsel, cmp_wsel, cnt_rsel, cmp_rsel;
   logic              en_hit, stat_hit;
   logic [CW-1:0]     cnt, cnt_nxt, cmp;
   logic              adv, en, flag;

   for (genvar k = 0; k < NWORDS; k++) begin : g_dec
      localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(word_ofs(CNT_BASE, k));
      localparam logic [ADDR_W-1:0] A_CMP = ADDR_W'(word_ofs(CMP_BASE, k));
      assign cnt_rsel[k] = (bus_addr == A_CNT);
      assign cmp_rsel[k] = (bus_addr == A_CMP);
      assign cnt_wsel[k] = bus_wr && cnt_rsel[k];
      assign cmp_wsel[k] = bus_wr && cmp_rsel[k];
   end

   assign en_hit   = (bus_addr == ADDR_W'(EN_OFS));
   assign stat_hit = (bus_addr == ADDR_W'(STAT_OFS));

   etime_counter #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wsel(cnt_wsel),
      .wdata(bus_wdata), .cnt(cnt), .cnt_nxt(cnt_nxt), .adv(adv));

   etime_alarm #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_alm (
      .clk(clk), .rst_n(rst_n), .adv(adv), .cnt_nxt(cnt_nxt),
      .cmp_wsel(cmp_wsel), .en_wr(bus_wr && en_hit),
      .stat_wr(bus_wr && stat_hit), .wdata(bus_wdata),
      .cmp(cmp), .en(en), .flag(flag));

   always_comb begin
      bus_rdata = '0;
      for (int k = 0; k < int'(NWORDS); k++) begin
         if (cnt_rsel[k]) bus_rdata = cnt[k*WORD_W +: WORD_W];
         if (cmp_rsel[k]) bus_rdata = cmp[k*WORD_W +: WORD_W];
      end
      if (en_hit)   bus_rdata = {{(WORD_W-1){1'b0}}, en};
      if (stat_hit) bus_rdata = {{(WORD_W-1){1'b0}}, flag};
   end

   assign irq = flag & en;

   // R9: interrupt only with the enable bit set
   a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && en_hit && !bus_wdata[0]) |=> !irq);
endmodule

// File: tb/elapsed_alarm_timer_tb.sv
`timescale 1ns/100ps
module elapsed_alarm_timer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        irq;

   int total = 0;
   int bad = 0;
   logic        rd_pending = 1'b0;
   int unsigned exp_q[$];
   string       tag_q[$];

   always #2.5 clk = ~clk;

   elapsed_alarm_timer u_dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

   task automatic check(input string tag, input int unsigned act, input int unsigned exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: compare scheduled reads away from the clock edges
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (rd_pending && exp_q.size() > 0) begin
            check(tag_q.pop_front(), int'(bus_rdata), exp_q.pop_front());
         end
      end
   end

   task automatic rd(input logic [4:0] a, input int unsigned exp, input string tag);
      @(negedge clk);
      bus_addr = a; bus_wr = 1'b0; tick_en = 1'b0;
      exp_q.push_back(exp); tag_q.push_back(tag);
      rd_pending = 1'b1;
      @(negedge clk);
      rd_pending = 1'b0;
   endtask

   task automatic peek(input logic [4:0] a, output int unsigned v);
      @(negedge clk);
      bus_addr = a; bus_wr = 1'b0; tick_en = 1'b0;
      #1 v = int'(bus_rdata);
   endtask

   task automatic wr(input logic [4:0] a, input logic [15:0] d, input logic tk);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1; tick_en = tk;
      @(negedge clk);
      bus_wr = 1'b0; tick_en = 1'b0;
   endtask

   task automatic ticks(input int n);
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = 5'h06; tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
   endtask

   task automatic chk_irq(input logic exp, input string tag);
      @(negedge clk);
      #1 check(tag, int'(irq), int'(exp));
   endtask

   task automatic rd_cnt(input logic [47:0] v, input string tag);
      rd(5'h00, int'(v[15:0]), tag);
      rd(5'h02, int'(v[31:16]), tag);
      rd(5'h04, int'(v[47:32]), tag);
   endtask

   initial begin
      #(200000 * 5);
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int unsigned lo, mi, hi, secs;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd_cnt(48'h0, "R1 count after reset");
      rd(5'h08, 0, "R1 cmp low"); rd(5'h0A, 0, "R1 cmp mid"); rd(5'h0C, 0, "R1 cmp high");
      rd(5'h10, 0, "R1 enable"); rd(5'h1E, 0, "R1 status");
      chk_irq(1'b0, "R1 irq");

      // R2 and R3 counting
      ticks(5);
      rd(5'h00, 5, "R2 five ticks");
      repeat (4) @(negedge clk);
      rd(5'h00, 5, "R3 idle holds");

      // R4 word loads, R2 carry across words
      wr(5'h00, 16'hFFFE, 1'b0); wr(5'h02, 16'hFFFF, 1'b0); wr(5'h04, 16'h0001, 1'b0);
      rd_cnt(48'h0001_FFFF_FFFE, "R4 load words");
      ticks(3);
      rd_cnt(48'h0002_0000_0001, "R2 carry");

      // R4 write drops simultaneous tick
      wr(5'h00, 16'h0100, 1'b1);
      rd_cnt(48'h0002_0000_0100, "R4 write beats tick");
      ticks(1);
      rd(5'h00, 16'h0101, "R4 resume from load");

      // R4 seconds layout: 3 s
      wr(5'h04, 16'h0, 1'b0); wr(5'h02, 16'h1, 1'b0); wr(5'h00, 16'h8000, 1'b0);
      peek(5'h00, lo); peek(5'h02, mi); peek(5'h04, hi);
      secs = (hi << 17) | (mi << 1) | (lo >> 15);
      check("R4 seconds", secs, 3);

      // R5 compare readback; count is 0x18000, compare 0x18004
      wr(5'h08, 16'h8004, 1'b0); wr(5'h0A, 16'h0001, 1'b0); wr(5'h0C, 16'h0000, 1'b0);
      rd(5'h08, 16'h8004, "R5 cmp low"); rd(5'h0A, 1, "R5 cmp mid"); rd(5'h0C, 0, "R5 cmp high");

      // R6 and R9 alarm
      ticks(3);
      rd(5'h1E, 0, "R6 no flag before match");
      ticks(1);
      rd(5'h1E, 1, "R6 flag on match tick");
      chk_irq(1'b0, "R9 flag masked");
      wr(5'h10, 16'h1, 1'b0);
      chk_irq(1'b1, "R9 irq enabled");
      wr(5'h1E, 16'h0, 1'b0);
      rd(5'h1E, 1, "R7 write zero keeps");
      wr(5'h1E, 16'h1, 1'b0);
      rd(5'h1E, 0, "R7 write one clears");
      chk_irq(1'b0, "R9 irq after clear");

      // R6 writes making equal do not set; count 0x18004 == cmp
      wr(5'h00, 16'h8004, 1'b0);
      wr(5'h08, 16'h8004, 1'b0);
      rd(5'h1E, 0, "R6 write-equal no flag");
      ticks(1);
      rd(5'h1E, 0, "R6 past match no flag");

      // R8 set beats clear; count 0x18005, cmp 0x18006
      wr(5'h08, 16'h8006, 1'b0);
      wr(5'h1E, 16'h1, 1'b1);
      rd(5'h1E, 1, "R8 set wins");
      rd(5'h00, 16'h8006, "R8 tick taken");

      // R10 unmapped
      rd(5'h06, 0, "R10 unmapped read");
      wr(5'h06, 16'hFFFF, 1'b0);
      wr(5'h14, 16'hFFFF, 1'b0);
      rd_cnt(48'h0000_0001_8006, "R10 count unchanged");
      rd(5'h08, 16'h8006, "R10 cmp unchanged");
      rd(5'h10, 1, "R10 enable unchanged");
      rd(5'h14, 0, "R10 unmapped read 0x14");

      repeat (3) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule